// File: doc/BRIEF.md
# PHY Management Register Bridge

This block sits behind a host register port and gives software access to a local bank of thirty-two 16-bit PHY registers without any serial management wire. The host writes one 32-bit command word, which carries a data field, a register index, a PHY address and an opcode. The bridge handles the command completely in the clock edge that accepts it. It checks the addressed register's read and write rights, and on a read it loads the stored value into the data field. It then latches the resulting word, with its ready and error flags, into a control register that the host can read at any time.

Each accepted command also produces a one-cycle completion pulse, which the chip's interrupt logic uses as an access-complete cause. The bank comes out of reset holding the standard values of a gigabit copper PHY with the link up. Only one PHY address answers; commands aimed anywhere else leave the bank alone and mark the previous result as failed.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: After a synchronous reset the control register reads 0x00000000 and the completion pulse is low.
- R2: A command whose PHY address field (bits [25:21]) is not 1 leaves the bank unchanged and sets the control register to its previous value with error (bit 30) and ready (bit 28) set.
- R3: A read (bit 27 set) of a readable register loads the control register with the command word, its bits [15:0] replaced by the stored value and ready set. Opcode 11 is handled as a read.
- R4: A read of a register without read right loads the command word unchanged except that error and ready are set.
- R5: A write (opcode bits [27:26] = 01) to a writable register stores bits [15:0] at the register index in bits [20:16], and loads the command word with ready set.
- R6: A write to a register without write right leaves the bank unchanged and loads the command word with error and ready set.
- R7: Every accepted command sets ready and raises the completion pulse for exactly the one cycle after acceptance. With no command, the pulse stays low and the control register holds its value.
- R8: The registers at indices 0, 4, 9, 16 and 20 are read/write. The registers at indices 1, 2, 3, 5, 10, 17 and 21 are read-only. All other indices have neither right.
- R9: The reset contents are: index 0 = 0x1140, 1 = 0x796D, 2 = 0x0141, 3 = 0x0C20, 4 = 0x0DE1, 5 = 0x01E0, 9 = 0x0E00, 10 = 0x3C00, 16 = 0x0360, 17 = 0xAC00, 20 = 0x0D60. Every other index, including 21, holds 0.
- R10: A command with opcode 00 changes no bank entry and loads the command word with ready set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host writes a command word this cycle |
| cmd_word | input | 32 | Command word written by the host |
| ctrl_word | output | 32 | Current control register contents seen by host reads |
| access_done | output | 1 | Completion interrupt cause, one cycle per command |

## Verification
The bench first reads every index after reset to confirm the reset values. This catches a wrong constant or a rights table shifted by one entry. It aims writes at read-only and unlisted registers and reads them back, so a design that ignores the write right would show the new data. Commands sent to a foreign PHY address follow a known result, which exposes a design that echoes the new command instead of keeping the previous word. A long random mix, including opcode 11 and opcode 00 and host-set error bits, is checked against a bench model of the bank. That mix exposes a design that decodes opcode priority wrongly or fails to clear or merge the flags.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int WORD_W     = 32;
    localparam int DATA_W     = 16;
    localparam int NUM_REGS   = 32;
    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int PHY_W      = 5;

    localparam int IDX_LSB    = 16;
    localparam int PHY_LSB    = 21;
    localparam int OP_WR_BIT  = 26;
    localparam int OP_RD_BIT  = 27;
    localparam int READY_BIT  = 28;
    localparam int ERROR_BIT  = 30;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_READ2 = 2'b11
    } mgmt_op_e;

    typedef struct packed {
        logic can_rd;
        logic can_wr;
    } reg_rights_t;

    typedef struct packed {
        logic [WORD_W-1:0] raw;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  idx;
        logic [PHY_W-1:0]  phy;
        mgmt_op_e          op;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t split_cmd(input logic [WORD_W-1:0] w);
        mgmt_cmd_t c;
        c.raw  = w;
        c.data = w[DATA_W-1:0];
        c.idx  = w[IDX_LSB +: IDX_W];
        c.phy  = w[PHY_LSB +: PHY_W];
        c.op   = mgmt_op_e'(w[OP_RD_BIT:OP_WR_BIT]);
        return c;
    endfunction

    function automatic reg_rights_t rights_of(input int idx);
        reg_rights_t r;
        case (idx)
            0, 4, 9, 16, 20:        r = '{can_rd: 1'b1, can_wr: 1'b1};
            1, 2, 3, 5, 10, 17, 21: r = '{can_rd: 1'b1, can_wr: 1'b0};
            default:                r = '{can_rd: 1'b0, can_wr: 1'b0};
        endcase
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] reset_value_of(input int idx);
        case (idx)
            0:       return 16'h1140;
            1:       return 16'h796D;
            2:       return 16'h0141;
            3:       return 16'h0C20;
            4:       return 16'h0DE1;
            5:       return 16'h01E0;
            9:       return 16'h0E00;
            10:      return 16'h3C00;
            16:      return 16'h0360;
            17:      return 16'hAC00;
            20:      return 16'h0D60;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/phy_access_rights.sv
module phy_access_rights
    import phy_mgmt_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic [IDX_W-1:0] idx,
    output reg_rights_t      rights
);
    reg_rights_t table_q [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_rights
        assign table_q[g] = rights_of(g);
    end

    assign rights = table_q[idx];
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
    import phy_mgmt_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int DW     = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic             wr_allowed,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] cells [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_cell
        localparam logic [DW-1:0] INIT = DW'(reset_value_of(g));
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= INIT;
            else if (we && idx == IDX_W'(g))
                cells[g] <= wdata;
        end
    end

    assign rdata = cells[idx];

    // A store may only reach a register that grants write access
    assert_store_needs_right_R6: assert property (@(posedge clk) disable iff (rst)
        we |-> wr_allowed);

    // The addressed cell is untouched when no store is issued
    assert_cell_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !we |=> rdata == $past(rdata) || idx != $past(idx));
endmodule

// File: rtl/phy_cmd_engine.sv
module phy_cmd_engine
    import phy_mgmt_pkg::*;
#(
    parameter logic [PHY_W-1:0] LOCAL_PHY = 5'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  reg_rights_t       rights,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic [IDX_W-1:0]  bank_idx,
    output logic              bank_we,
    output logic [DATA_W-1:0] bank_wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic              done_q
);
    mgmt_cmd_t         cmd;
    logic [WORD_W-1:0] next_ctrl;
    logic              fail;
    logic [WORD_W-1:0] flags;

    assign cmd        = split_cmd(cmd_word);
    assign bank_idx   = cmd.idx;
    assign bank_wdata = cmd.data;

    always_comb begin
        next_ctrl = cmd.raw;
        fail      = 1'b0;
        bank_we   = 1'b0;
        if (cmd.phy != LOCAL_PHY) begin
            next_ctrl = ctrl_q;
            fail      = 1'b1;
        end else begin
            unique case (cmd.op)
                OP_READ, OP_READ2: begin
                    if (rights.can_rd)
                        next_ctrl = {cmd.raw[WORD_W-1:DATA_W], bank_rdata};
                    else
                        fail = 1'b1;
                end
                OP_WRITE: begin
                    if (rights.can_wr)
                        bank_we = cmd_valid;
                    else
                        fail = 1'b1;
                end
                default: ;
            endcase
        end
        flags = '0;
        flags[READY_BIT] = 1'b1;
        flags[ERROR_BIT] = fail;
        next_ctrl = next_ctrl | flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= cmd_valid;
            if (cmd_valid)
                ctrl_q <= next_ctrl;
        end
    end

    assert_ready_after_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> ctrl_q[READY_BIT] && done_q);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !done_q && $stable(ctrl_q));

    assert_foreign_keeps_word_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_word[PHY_LSB +: PHY_W] != LOCAL_PHY
        |=> ctrl_q[ERROR_BIT] && ctrl_q[27:0] == ($past(ctrl_q[27:0]) | 28'h0000000) );

    assert_no_store_foreign_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_word[PHY_LSB +: PHY_W] != LOCAL_PHY |-> !bank_we);

    assert_read_keeps_upper_R3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_word[OP_RD_BIT] && cmd_word[PHY_LSB +: PHY_W] == LOCAL_PHY
        |=> ctrl_q[27:16] == $past(cmd_word[27:16]));
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              access_done
);
    logic [IDX_W-1:0]  bank_idx;
    logic              bank_we;
    logic [DATA_W-1:0] bank_wdata;
    logic [DATA_W-1:0] bank_rdata;
    reg_rights_t       rights;

    phy_access_rights #(.N_REGS(NUM_REGS)) u_rights (
        .idx    (bank_idx),
        .rights (rights)
    );

    phy_reg_bank #(.N_REGS(NUM_REGS), .DW(DATA_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .we         (bank_we),
        .idx        (bank_idx),
        .wdata      (bank_wdata),
        .wr_allowed (rights.can_wr),
        .rdata      (bank_rdata)
    );

    phy_cmd_engine #(.LOCAL_PHY(5'd1)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_word   (cmd_word),
        .rights     (rights),
        .bank_rdata (bank_rdata),
        .bank_idx   (bank_idx),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .ctrl_q     (ctrl_word),
        .done_q     (access_done)
    );
endmodule

// File: tb/phy_mgmt_bridge_test.sv
module phy_mgmt_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] ctrl_word;
    logic        access_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [15:0] model [32];
    logic [31:0] prev_ctrl;

    always #2 clk = ~clk;

    phy_mgmt_bridge uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ctrl_word(ctrl_word), .access_done(access_done)
    );

    function automatic bit may_rd(input int i);
        return (i inside {0, 4, 9, 16, 20, 1, 2, 3, 5, 10, 17, 21});
    endfunction
    function automatic bit may_wr(input int i);
        return (i inside {0, 4, 9, 16, 20});
    endfunction
    function automatic logic [15:0] init_val(input int i);
        case (i)
            0: return 16'h1140;  1: return 16'h796D;  2: return 16'h0141;
            3: return 16'h0C20;  4: return 16'h0DE1;  5: return 16'h01E0;
            9: return 16'h0E00; 10: return 16'h3C00; 16: return 16'h0360;
            17: return 16'hAC00; 20: return 16'h0D60;
            default: return 16'h0000;
        endcase
    endfunction
    function automatic logic [31:0] mk(input logic [1:0] op, input int phy, input int idx,
                                       input logic [15:0] d);
        return {4'b0000, op, phy[4:0], idx[4:0], d};
    endfunction

    // expected control word; updates the bank model on permitted writes
    function automatic logic [31:0] expect_word(input logic [31:0] c);
        int i = int'(c[20:16]);
        if (c[25:21] != 5'd1) return prev_ctrl | 32'h5000_0000;
        if (c[27]) begin
            if (may_rd(i)) return {c[31:16], model[i]} | 32'h1000_0000;
            return c | 32'h5000_0000;
        end
        if (c[26]) begin
            if (may_wr(i)) begin model[i] = c[15:0]; return c | 32'h1000_0000; end
            return c | 32'h5000_0000;
        end
        return c | 32'h1000_0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic [31:0] c);
        logic [31:0] e;
        e = expect_word(c);
        cmd_word  = c;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(req, ctrl_word, e);
        chk({req, " done pulse R7"}, {31'b0, access_done}, 32'd1);
        prev_ctrl = e;
        @(negedge clk);
        chk("R7 pulse width", {31'b0, access_done}, 32'd0);
        chk("R7 hold", ctrl_word, e);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = init_val(i);
        prev_ctrl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 ctrl reset", ctrl_word, 32'h0);
        chk("R1 done reset", {31'b0, access_done}, 32'd0);

        // R9 / R8: read every index after reset
        for (int i = 0; i < 32; i++) issue("R9 R8 reset read", mk(2'b10, 1, i, 16'h0));

        issue("R5 write rw", mk(2'b01, 1, 4, 16'hBEEF));
        issue("R5 readback", mk(2'b10, 1, 4, 16'h1234));
        issue("R6 write ro", mk(2'b01, 1, 1, 16'h0000));
        issue("R6 ro readback", mk(2'b10, 1, 1, 16'h0));
        issue("R6 write unlisted", mk(2'b01, 1, 7, 16'h5555));
        issue("R4 read unlisted", mk(2'b10, 1, 7, 16'hA5A5));
        issue("R2 foreign phy write", mk(2'b01, 2, 0, 16'hFFFF));
        issue("R2 bank untouched", mk(2'b10, 1, 0, 16'h0));
        issue("R2 foreign phy zero", mk(2'b10, 0, 3, 16'h0));
        issue("R10 opcode none", mk(2'b00, 1, 9, 16'h7777));
        issue("R10 bank untouched", mk(2'b10, 1, 9, 16'h0));
        issue("R3 opcode 11 reads", mk(2'b11, 1, 16, 16'h0101));

        void'($urandom(32'd1234));
        for (int n = 0; n < 400; n++) begin
            logic [31:0] c;
            c = $urandom();
            c[28] = 1'b0;
            if ($urandom_range(0, 3) != 0) c[25:21] = 5'd1;
            if ($urandom_range(0, 1) == 0) c[20:16] = 5'(($urandom_range(0, 5) == 0) ? 21 : $urandom_range(0, 20));
            issue("R3 R5 random mix", c);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule